// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from five sources for a small microcontroller core and turns them into a single interrupt-take strobe with an 8-bit vector address. Each source owns a sticky request flag. A one-cycle hardware event pulse sets the flag, and software can also write the flag register directly to set or clear any flag. Every source has its own enable bit, and a global enable sits above all of them.

Requests are examined only when the core raises its instruction-phase strobe. If the global enable is set and at least one enabled flag is pending at that clock edge, the lowest-numbered (highest-priority) such source wins. The block then pulses the take output for one cycle with that source's vector. In the same cycle it drops the winner's flag and the global enable, so the core is not interrupted again until software re-arms the global enable, which models the return from the service routine. Lower-priority flags stay pending and are taken at the first strobe after re-arming.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset every request flag, every source enable and the global enable read back as 0, and `take` is 0.
- R2: A one-cycle pulse on `hw_evt[i]` sets flag i from the next cycle on. The flag stays set, with no strobe or write, until it is serviced or cleared by software.
- R3: Writing the flag register (`reg_sel`=1) loads flags from `reg_wdata[4:0]`, with bit i being source i, and reads back the same way. If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: `take` rises only in the cycle after a clock edge where `phase_stb` was 1, and it lasts one cycle. A flag set at that same edge is not yet seen, so it is taken at the following strobe.
- R5: Source 0 has the highest priority and source 4 the lowest. The vectors for sources 0..4 are 0x04, 0x08, 0x0C, 0x14 and 0x18, and 0x10 is never produced. `vec_addr` is valid while `take` is 1.
- R6: A source whose enable bit (`reg_sel`=0, `reg_wdata[i]` for source i) is 0 is never taken, and its flag stays pending.
- R7: When the global enable (`reg_sel`=0, bit 7) is 0, no source is taken, whatever flags and enables are set.
- R8: On a take, the global enable and the winning source's flag read 0 from the next cycle on. All other flags keep their values.
- R9: Writing the global enable back to 1 while an enabled flag is pending causes that flag to be taken at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_stb | input | 1 | Instruction-phase sampling strobe |
| hw_evt | input | 5 | Hardware event pulses, bit i for source i |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = control (enables, global enable in bit 7), 1 = flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| take | output | 1 | One-cycle interrupt-take strobe |
| vec_addr | output | 8 | Vector address of the taken source |

## Verification
The hardest case to reach from the ports is a collision inside one clock edge: an event that lands on the strobe edge itself, or an event together with a software clear of the same flag. The bench lines up these pulses on a single negedge so that both land on the same posedge. It also sweeps all 1024 pairs of flag pattern and enable pattern, so that every priority conflict is loaded through the register port before a single strobe. It then checks the vector and the remaining flags against a winner computed arithmetically.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

    localparam int NSRC       = 5;
    localparam int IDXW       = $clog2(NSRC);
    localparam int DW         = 8;
    localparam int VEC_STRIDE = 4;
    localparam int SKIP_SLOT  = 4;
    localparam int GEN_BIT    = DW - 1;

    typedef logic [NSRC-1:0] src_mask_t;
    typedef logic [DW-1:0]   word_t;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_FLAG = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [IDXW-1:0]   idx;
    } pick_t;

    typedef struct packed {
        logic   take;
        word_t  addr;
    } take_t;

    // Slot numbers start at 1; one slot is reserved and skipped.
    function automatic word_t vec_of(input logic [IDXW-1:0] idx);
        int unsigned slot;
        slot = int'(idx) + 1;
        if (slot >= SKIP_SLOT)
            slot = slot + 1;
        return word_t'(slot * VEC_STRIDE);
    endfunction

    function automatic src_mask_t onehot_of(input logic [IDXW-1:0] idx);
        return src_mask_t'(1) << idx;
    endfunction

endpackage

// File: rtl/vec_irq_flags.sv
module vec_irq_flags
    import vec_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_mask_t hw_evt,
    input  logic      sw_wr,
    input  src_mask_t sw_data,
    input  src_mask_t clr_mask,
    output src_mask_t flags
);

    src_mask_t flags_nxt;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_comb begin
            flags_nxt[i] = flags[i];
            if (sw_wr)
                flags_nxt[i] = sw_data[i];
            if (clr_mask[i])
                flags_nxt[i] = 1'b0;
            if (hw_evt[i])
                flags_nxt[i] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else
                flags[i] <= flags_nxt[i];
        end

        // R2 / R3: an event is never lost, even against a clear
        assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
            hw_evt[i] |=> flags[i]);

        // R2: flag is sticky without write or service
        assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !sw_wr && !clr_mask[i]) |=> flags[i]);

        // R8: serviced flag drops unless a new event arrives
        assert_serviced_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[i] && !hw_evt[i]) |=> !flags[i]);
    end

endmodule

// File: rtl/vec_irq_regs.sv
module vec_irq_regs
    import vec_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctrl,
    input  word_t     wdata,
    input  logic      take_now,
    input  reg_sel_e  sel,
    input  src_mask_t flags,
    output src_mask_t en,
    output logic      gen,
    output word_t     rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            gen <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en  <= wdata[NSRC-1:0];
                gen <= wdata[GEN_BIT];
            end
            if (take_now)
                gen <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel == SEL_FLAG) begin
            rdata[NSRC-1:0] = flags;
        end else begin
            rdata[NSRC-1:0] = en;
            rdata[GEN_BIT]  = gen;
        end
    end

    // R8: a take always drops the global enable
    assert_take_clears_gen_R8: assert property (@(posedge clk) disable iff (rst)
        take_now |=> !gen);

    // R9: re-arm write without a take sets the global enable
    assert_rearm_sets_gen_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wdata[GEN_BIT] && !take_now) |=> gen);

endmodule

// File: rtl/vec_irq_arb.sv
module vec_irq_arb
    import vec_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      phase_stb,
    input  src_mask_t flags,
    input  src_mask_t en,
    input  logic      gen,
    output src_mask_t clr_mask,
    output logic      take_now,
    output take_t     out_q
);

    src_mask_t cand;
    pick_t     pick;

    assign cand = flags & en & {NSRC{gen}};

    // Lowest index wins: scan from the top so the last hit is the winner.
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick.valid = 1'b1;
                pick.idx   = IDXW'(i);
            end
        end
    end

    assign take_now = phase_stb && pick.valid;
    assign clr_mask = take_now ? onehot_of(pick.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.take <= take_now;
            if (take_now)
                out_q.addr <= vec_of(pick.idx);
        end
    end

    // R4: take only follows a strobe edge
    assert_take_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        out_q.take |-> $past(phase_stb));

    // R5: at most one source serviced, reserved vector never used
    assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_mask));
    assert_no_reserved_vec_R5: assert property (@(posedge clk) disable iff (rst)
        out_q.take |-> (out_q.addr != word_t'((SKIP_SLOT) * VEC_STRIDE)));

    // R6 / R7: a grant needs the global and the per-source enable
    assert_grant_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |-> (gen && ((clr_mask & en) == clr_mask)));
    assert_gen_gates_take_R7: assert property (@(posedge clk) disable iff (rst)
        out_q.take |-> $past(gen));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vec_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_stb,
    input  logic [NSRC-1:0]  hw_evt,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             take,
    output logic [DW-1:0]    vec_addr
);

    reg_sel_e  sel;
    src_mask_t flags;
    src_mask_t en;
    src_mask_t clr_mask;
    logic      gen;
    logic      take_now;
    take_t     out_q;

    assign sel = reg_sel_e'(reg_sel);

    vec_irq_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .hw_evt   (hw_evt),
        .sw_wr    (reg_wr && sel == SEL_FLAG),
        .sw_data  (reg_wdata[NSRC-1:0]),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    vec_irq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (reg_wr && sel == SEL_CTRL),
        .wdata    (reg_wdata),
        .take_now (take_now),
        .sel      (sel),
        .flags    (flags),
        .en       (en),
        .gen      (gen),
        .rdata    (reg_rdata)
    );

    vec_irq_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .phase_stb (phase_stb),
        .flags     (flags),
        .en        (en),
        .gen       (gen),
        .clr_mask  (clr_mask),
        .take_now  (take_now),
        .out_q     (out_q)
    );

    assign take     = out_q.take;
    assign vec_addr = out_q.addr;

    // R4: take is a single-cycle pulse (gen drops on every take)
    assert_take_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    // R1: state right after reset is idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!take && !gen && flags == '0 && en == '0));

endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       phase_stb = 1'b0;
    logic [4:0] hw_evt = '0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       take;
    logic [7:0] vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .phase_stb(phase_stb), .hw_evt(hw_evt),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .take(take), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_vec(input int w);
        return (w < 3) ? 8'(4 * (w + 1)) : 8'(4 * (w + 2));
    endfunction

    // All tasks start and end right after a negedge.
    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic strobe;
        phase_stb = 1'b1;
        @(negedge clk);
        phase_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 take", {7'b0, take}, 8'h00);
        rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
        rd(1'b1, d); chk("R1 flags", d, 8'h00);

        // R2 event sets sticky flag
        hw_evt = 5'b00100;
        @(negedge clk);
        hw_evt = '0;
        repeat (5) @(negedge clk);
        rd(1'b1, d); chk("R2 sticky flag", d, 8'h04);

        // R3 write and readback, event beats clear
        wr(1'b1, 8'h15);
        rd(1'b1, d); chk("R3 write flags", d, 8'h15);
        hw_evt = 5'b01000;
        wr(1'b1, 8'h00);
        hw_evt = '0;
        rd(1'b1, d); chk("R3 event wins over clear", d, 8'h08);

        // R4 no take without strobe
        wr(1'b0, 8'h9F);
        repeat (4) begin
            @(negedge clk);
            chk("R4 no strobe no take", {7'b0, take}, 8'h00);
        end
        // R4 event on the strobe edge is not seen by that strobe
        wr(1'b1, 8'h00);
        hw_evt = 5'b00010; phase_stb = 1'b1;
        @(negedge clk);
        hw_evt = '0; phase_stb = 1'b0;
        chk("R4 same-edge event not taken", {7'b0, take}, 8'h00);
        strobe;
        chk("R4 taken next strobe", {7'b0, take}, 8'h01);
        chk("R5 vector source1", vec_addr, 8'h08);
        @(negedge clk);
        chk("R4 pulse one cycle", {7'b0, take}, 8'h00);

        // R7 / R9 re-arm sequence
        wr(1'b1, 8'h18);
        wr(1'b0, 8'h9F);
        strobe;
        chk("R5 vector source3", vec_addr, 8'h14);
        @(negedge clk);
        strobe;
        chk("R7 gen off no take", {7'b0, take}, 8'h00);
        wr(1'b0, 8'h9F);
        strobe;
        chk("R9 rearm take", {7'b0, take}, 8'h01);
        chk("R9 rearm vector source4", vec_addr, 8'h18);
        @(negedge clk);

        // R7 sweep with global enable off
        for (int f = 1; f < 32; f++) begin
            wr(1'b1, 8'(f));
            wr(1'b0, 8'h1F);
            strobe;
            chk("R7 gen off sweep", {7'b0, take}, 8'h00);
            rd(1'b1, d); chk("R7 flags kept", d, 8'(f));
        end

        // R5 R6 R8 full sweep of flags x enables
        for (int f = 0; f < 32; f++) begin
            for (int e = 0; e < 32; e++) begin
                int w;
                logic [4:0] m;
                logic [7:0] fexp;
                logic [7:0] cexp;
                m = 5'(f & e);
                w = -1;
                for (int i = 4; i >= 0; i--) if (m[i]) w = i;
                wr(1'b1, 8'(f));
                wr(1'b0, 8'h80 | 8'(e));
                strobe;
                if (w >= 0) begin
                    chk("R5 take", {7'b0, take}, 8'h01);
                    chk("R5 priority vector", vec_addr, exp_vec(w));
                    fexp = 8'(f) & ~(8'h01 << w);
                    cexp = 8'(e);
                end else begin
                    chk("R6 no enabled source no take", {7'b0, take}, 8'h00);
                    fexp = 8'(f);
                    cexp = 8'h80 | 8'(e);
                end
                @(negedge clk);
                rd(1'b1, d); chk("R8 flags after strobe", d, fexp);
                rd(1'b0, d); chk("R8 ctrl after strobe", d, cexp);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule